// File: doc/BRIEF.md
# Bridge Address Window Translator

This block holds a bank of programmable address windows of the kind a bus-to-bus bridge uses to decide which accesses cross over and where they land. Each window has an enable, an access class, a start address, an exclusive bound and an offset. Software programs these fields through a simple word-addressed write port. The lookup side takes one request per cycle. A request carries an address, a 5-bit access class and a direction. One cycle later the block returns whether a window matched, which window matched, and the address as it appears on the other bus.

Lookups run in two directions. A reverse lookup checks the incoming address against the window range and then adds the offset. A forward lookup subtracts the offset first and then range-checks the difference. Windows whose index is a multiple of four use 4 KiB granularity. All other windows use 64 KiB granularity. A parameter models an older revision in which the upper half of the bank does not exist.

Top module: `xw_translator`

## Requirements
- R1: After reset every window is disabled, `rsp_valid` is low, and every lookup misses.
- R2: A write selects one field of the window given by `wr_win` through `wr_sel`: 0 is control, 1 is start, 2 is bound and 3 is offset. Writes with `wr_sel` of 4 or above change nothing and do not delay any window.
- R3: Start, bound and offset are stored with their low bits forced to zero. Bits 11:0 are cleared for windows 0 and 4. Bits 15:0 are cleared for every other window.
- R4: Control bit 31 enables a window. A window whose enable bit is clear never hits.
- R5: The window class is {control[18:16], control[14], control[12]}, that is {space code, program, supervisor}. A hit needs `req_class` to equal this class exactly. Space codes 3 to 7 are invalid and never hit.
- R6: A reverse lookup (`req_reverse`=1) hits when start ≤ address < bound. The result is address + offset modulo 2^32.
- R7: A forward lookup computes x = address − offset modulo 2^32. It hits when start ≤ x < bound, and the result is x.
- R8: When several windows hit, the lowest-numbered one is reported in `rsp_win` and supplies `rsp_addr`.
- R9: A request sampled with `req_valid` at one clock edge is answered at the next edge. The answer uses the window state from before any write at that same edge. On a miss, and with no request, `rsp_hit`, `rsp_win` and `rsp_addr` are all zero.
- R10: When `UPPER_PRESENT` is 0, windows 4 to 7 never hit.
- R11: Writing control with bit 31 clear stops hits from the next request. Any write to a window's control, start, bound or offset keeps that window from hitting on the request sampled at the following edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_win | input | 3 | Window index of the write |
| wr_sel | input | 3 | Field select: 0 control, 1 start, 2 bound, 3 offset |
| wr_data | input | 32 | Write data |
| req_valid | input | 1 | Lookup request strobe |
| req_reverse | input | 1 | 1: reverse lookup, 0: forward lookup |
| req_class | input | 5 | Requested class {space[2:0], program, supervisor} |
| req_addr | input | 32 | Address to translate |
| rsp_valid | output | 1 | Lookup answer present |
| rsp_hit | output | 1 | A window matched |
| rsp_win | output | 3 | Index of the matching window |
| rsp_addr | output | 32 | Translated address |

## Verification
The hardest state to reach from the ports is the single cycle in which a freshly written window is held back. The other is a lookup that races a write in the same cycle. The stimulus issues the lookup on the cycle directly after a field write, and once together with a disabling write. This shows that both the settle rule and the pre-write view are visible at the outputs. A second instance built with the upper half absent receives the same stimulus, so every overlap and priority sweep also covers the older revision.

// File: rtl/xw_pkg.sv
package xw_pkg;
  localparam int unsigned AW      = 32;
  localparam int unsigned CLS_W   = 5;
  localparam int unsigned SEL_W   = 3;
  localparam int unsigned EN_BIT  = 31;
  localparam int unsigned SPC_LSB = 16;
  localparam int unsigned PGM_BIT = 14;
  localparam int unsigned SUP_BIT = 12;
  localparam int unsigned SPC_MAX = 2;

  typedef logic [AW-1:0]    addr_t;
  typedef logic [CLS_W-1:0] cls_t;

  typedef enum logic [SEL_W-1:0] {
    SEL_CTRL  = 3'd0,
    SEL_START = 3'd1,
    SEL_BOUND = 3'd2,
    SEL_OFFS  = 3'd3
  } sel_e;

  // granularity mask: windows at a multiple of stride are fine-grained
  function automatic addr_t gran_mask(int unsigned idx, int unsigned stride,
                                      int unsigned fine, int unsigned coarse);
    int unsigned b;
    b = ((idx % stride) == 0) ? fine : coarse;
    return ~((addr_t'(1) << b) - addr_t'(1));
  endfunction

  function automatic cls_t ctrl_class(addr_t c);
    return {c[SPC_LSB+2:SPC_LSB], c[PGM_BIT], c[SUP_BIT]};
  endfunction

  function automatic logic space_ok(cls_t c);
    return c[CLS_W-1:2] <= 3'(SPC_MAX);
  endfunction

  function automatic logic in_range(addr_t a, addr_t lo, addr_t hi);
    return (a >= lo) && (a < hi);
  endfunction

  function automatic addr_t fwd_map(addr_t a, addr_t o);
    return a - o;
  endfunction

  function automatic addr_t rev_map(addr_t a, addr_t o);
    return a + o;
  endfunction
endpackage

// File: rtl/xw_regbank.sv
module xw_regbank
  import xw_pkg::*;
#(
  parameter int unsigned NUM_WIN     = 8,
  parameter int unsigned FINE_STRIDE = 4,
  parameter int unsigned FINE_BITS   = 12,
  parameter int unsigned COARSE_BITS = 16,
  localparam int unsigned IW = $clog2(NUM_WIN)
)(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IW-1:0]    wr_win,
  input  logic [SEL_W-1:0] wr_sel,
  input  addr_t            wr_data,
  output cls_t             cls_o   [NUM_WIN],
  output addr_t            start_o [NUM_WIN],
  output addr_t            bound_o [NUM_WIN],
  output addr_t            offs_o  [NUM_WIN],
  output logic [NUM_WIN-1:0] eff_en_o
);
  for (genvar i = 0; i < NUM_WIN; i++) begin : g_win
    localparam addr_t MASK = gran_mask(i, FINE_STRIDE, FINE_BITS, COARSE_BITS);
    logic  sel_here;
    logic  touch;
    logic  en_q;
    logic  arm_q;
    cls_t  cls_q;
    addr_t start_q;
    addr_t bound_q;
    addr_t offs_q;

    assign sel_here = wr_en && (wr_win == IW'(i));
    assign touch    = sel_here && (wr_sel <= SEL_OFFS);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        en_q    <= 1'b0;
        arm_q   <= 1'b0;
        cls_q   <= '0;
        start_q <= '0;
        bound_q <= '0;
        offs_q  <= '0;
      end else begin
        if (sel_here && wr_sel == SEL_CTRL) begin
          en_q  <= wr_data[EN_BIT];
          cls_q <= ctrl_class(wr_data);
        end
        if (sel_here && wr_sel == SEL_START) start_q <= wr_data & MASK;
        if (sel_here && wr_sel == SEL_BOUND) bound_q <= wr_data & MASK;
        if (sel_here && wr_sel == SEL_OFFS)  offs_q  <= wr_data & MASK;
        arm_q <= !touch;
      end
    end

    assign cls_o[i]    = cls_q;
    assign start_o[i]  = start_q;
    assign bound_o[i]  = bound_q;
    assign offs_o[i]   = offs_q;
    assign eff_en_o[i] = en_q && arm_q;
  end
endmodule

// File: rtl/xw_win_match.sv
module xw_win_match
  import xw_pkg::*;
#(
  parameter bit PRESENT = 1'b1
)(
  input  logic  win_en,
  input  cls_t  win_cls,
  input  addr_t start,
  input  addr_t bound,
  input  addr_t offs,
  input  logic  req_reverse,
  input  cls_t  req_cls,
  input  addr_t req_addr,
  output logic  hit,
  output addr_t xaddr
);
  addr_t cand;
  logic  inr;
  logic  cls_eq;

  always_comb begin
    cand   = req_reverse ? req_addr : fwd_map(req_addr, offs);
    inr    = in_range(cand, start, bound);
    cls_eq = space_ok(win_cls) && (win_cls == req_cls);
  end

  assign xaddr = req_reverse ? rev_map(req_addr, offs) : cand;
  assign hit   = PRESENT && win_en && cls_eq && inr;
endmodule

// File: rtl/xw_prio_pick.sv
module xw_prio_pick #(
  parameter int unsigned N = 8,
  localparam int unsigned IW = $clog2(N)
)(
  input  logic [N-1:0]  req,
  output logic [N-1:0]  grant,
  output logic          any,
  output logic [IW-1:0] idx
);
  assign grant = req & (~req + N'(1));
  assign any   = |req;

  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) idx = IW'(i);
    end
  end
endmodule

// File: rtl/xw_translator.sv
module xw_translator
  import xw_pkg::*;
#(
  parameter int unsigned NUM_WIN       = 8,
  parameter int unsigned FINE_STRIDE   = 4,
  parameter int unsigned FINE_BITS     = 12,
  parameter int unsigned COARSE_BITS   = 16,
  parameter bit          UPPER_PRESENT = 1'b1,
  localparam int unsigned IW = $clog2(NUM_WIN)
)(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [IW-1:0] wr_win,
  input  logic [2:0]    wr_sel,
  input  logic [31:0]   wr_data,
  input  logic          req_valid,
  input  logic          req_reverse,
  input  logic [4:0]    req_class,
  input  logic [31:0]   req_addr,
  output logic          rsp_valid,
  output logic          rsp_hit,
  output logic [IW-1:0] rsp_win,
  output logic [31:0]   rsp_addr
);
  localparam int unsigned HALF = NUM_WIN / 2;

  cls_t  cls_w   [NUM_WIN];
  addr_t start_w [NUM_WIN];
  addr_t bound_w [NUM_WIN];
  addr_t offs_w  [NUM_WIN];
  addr_t xaddr_w [NUM_WIN];
  logic [NUM_WIN-1:0] eff_en_w;
  logic [NUM_WIN-1:0] hit_w;
  logic [NUM_WIN-1:0] pick_w;
  logic               any_w;
  logic [IW-1:0]      idx_w;
  addr_t              sel_addr_w;

  xw_regbank #(
    .NUM_WIN(NUM_WIN), .FINE_STRIDE(FINE_STRIDE),
    .FINE_BITS(FINE_BITS), .COARSE_BITS(COARSE_BITS)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_win(wr_win),
    .wr_sel(wr_sel), .wr_data(wr_data),
    .cls_o(cls_w), .start_o(start_w), .bound_o(bound_w), .offs_o(offs_w),
    .eff_en_o(eff_en_w)
  );

  for (genvar i = 0; i < NUM_WIN; i++) begin : g_match
    localparam bit PRESENT = UPPER_PRESENT || (i < HALF);
    xw_win_match #(.PRESENT(PRESENT)) u_match (
      .win_en(eff_en_w[i]), .win_cls(cls_w[i]),
      .start(start_w[i]), .bound(bound_w[i]), .offs(offs_w[i]),
      .req_reverse(req_reverse), .req_cls(req_class), .req_addr(req_addr),
      .hit(hit_w[i]), .xaddr(xaddr_w[i])
    );
  end

  xw_prio_pick #(.N(NUM_WIN)) u_pick (
    .req(hit_w), .grant(pick_w), .any(any_w), .idx(idx_w)
  );

  always_comb begin
    sel_addr_w = '0;
    for (int i = 0; i < NUM_WIN; i++) begin
      if (pick_w[i]) sel_addr_w = sel_addr_w | xaddr_w[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_win   <= '0;
      rsp_addr  <= '0;
    end else begin
      rsp_valid <= req_valid;
      rsp_hit   <= req_valid && any_w;
      rsp_win   <= (req_valid && any_w) ? idx_w : '0;
      rsp_addr  <= (req_valid && any_w) ? sel_addr_w : '0;
    end
  end
endmodule

// File: rtl/xw_translator_chk.sv
module xw_translator_chk #(
  parameter int unsigned NUM_WIN       = 8,
  parameter bit          UPPER_PRESENT = 1'b1,
  localparam int unsigned IW = $clog2(NUM_WIN)
)(
  input logic               clk,
  input logic               rst_n,
  input logic               wr_en,
  input logic [IW-1:0]      wr_win,
  input logic [2:0]         wr_sel,
  input logic               wr_en_bit,
  input logic               req_valid,
  input logic               rsp_valid,
  input logic               rsp_hit,
  input logic [IW-1:0]      rsp_win,
  input logic [31:0]        rsp_addr,
  input logic [NUM_WIN-1:0] eff_en,
  input logic [NUM_WIN-1:0] pick
);
  logic [NUM_WIN-1:0] eff_en_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) eff_en_d <= '0;
    else        eff_en_d <= eff_en;
  end

  AST_RSP_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid); // R9
  AST_NO_SPURIOUS_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid); // R9
  AST_MISS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_hit |-> (rsp_win == '0) && (rsp_addr == '0)); // R9
  AST_HIT_WAS_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_hit |-> eff_en_d[rsp_win]); // R4
  AST_SINGLE_PICK: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(pick)); // R8
  AST_UPPER_ABSENT: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_hit |-> (UPPER_PRESENT || (int'(rsp_win) < NUM_WIN / 2))); // R10
  AST_DISABLE_AT_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == 3'd0 && !wr_en_bit) |=> !eff_en[$past(wr_win)]); // R11
  AST_SETTLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel <= 3'd3) |=> !eff_en[$past(wr_win)]); // R11
endmodule

bind xw_translator xw_translator_chk #(
  .NUM_WIN(NUM_WIN), .UPPER_PRESENT(UPPER_PRESENT)
) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_win(wr_win), .wr_sel(wr_sel),
  .wr_en_bit(wr_data[31]), .req_valid(req_valid), .rsp_valid(rsp_valid),
  .rsp_hit(rsp_hit), .rsp_win(rsp_win), .rsp_addr(rsp_addr),
  .eff_en(eff_en_w), .pick(pick_w)
);

// File: tb/xw_translator_tb.sv
`timescale 1ns/1ps
module xw_translator_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic        wr_en = 1'b0;
  logic [2:0]  wr_win = '0, wr_sel = '0;
  logic [31:0] wr_data = '0;
  logic        req_valid = 1'b0, req_reverse = 1'b0;
  logic [4:0]  req_class = '0;
  logic [31:0] req_addr = '0;
  logic        n_valid, n_hit, o_valid, o_hit;
  logic [2:0]  n_win, o_win;
  logic [31:0] n_addr, o_addr;

  int checks = 0;
  int failures = 0;
  logic [31:0] s_ctrl [8];
  logic [31:0] s_start[8];
  logic [31:0] s_bound[8];
  logic [31:0] s_offs [8];

  xw_translator u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_win(wr_win), .wr_sel(wr_sel),
    .wr_data(wr_data), .req_valid(req_valid), .req_reverse(req_reverse),
    .req_class(req_class), .req_addr(req_addr), .rsp_valid(n_valid),
    .rsp_hit(n_hit), .rsp_win(n_win), .rsp_addr(n_addr));

  xw_translator #(.UPPER_PRESENT(1'b0)) u_old (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_win(wr_win), .wr_sel(wr_sel),
    .wr_data(wr_data), .req_valid(req_valid), .req_reverse(req_reverse),
    .req_class(req_class), .req_addr(req_addr), .rsp_valid(o_valid),
    .rsp_hit(o_hit), .rsp_win(o_win), .rsp_addr(o_addr));

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(input bit en, input int sp, input bit pg, input bit su);
    logic [31:0] c;
    c = '0;
    c[31] = en;
    c[18:16] = sp[2:0];
    c[14] = pg;
    c[12] = su;
    return c;
  endfunction

  function automatic logic [4:0] cls_of(input int sp, input bit pg, input bit su);
    return {sp[2:0], pg, su};
  endfunction

  // arithmetic restatement of the lookup rules over the shadow copy
  function automatic void model(input bit present, input bit rev, input logic [4:0] cls,
                                input logic [31:0] a, output logic hit,
                                output logic [2:0] win, output logic [31:0] xa);
    hit = 1'b0; win = '0; xa = '0;
    for (int w = 7; w >= 0; w--) begin
      logic [31:0] c, t;
      logic ok;
      c  = s_ctrl[w];
      t  = rev ? a : a - s_offs[w];
      ok = (present || w < 4) && c[31] && ({c[18:16], c[14], c[12]} == cls) &&
           (c[18:16] <= 3'd2) && (t >= s_start[w]) && (t < s_bound[w]);
      if (ok) begin
        hit = 1'b1;
        win = w[2:0];
        xa  = rev ? a + s_offs[w] : t;
      end
    end
  endfunction

  task automatic check_rsp(input string tag, input logic eh, input logic [2:0] ew,
                           input logic [31:0] ea, input logic oh, input logic [2:0] ow,
                           input logic [31:0] oa);
    chk(tag, "valid", 32'(n_valid), 32'd1);
    chk(tag, "hit",   32'(n_hit),   32'(eh));
    chk(tag, "win",   32'(n_win),   32'(ew));
    chk(tag, "addr",  n_addr,       ea);
    chk(tag, "old_valid", 32'(o_valid), 32'd1);
    chk(tag, "old_hit",   32'(o_hit),   32'(oh));
    chk(tag, "old_win",   32'(o_win),   32'(ow));
    chk(tag, "old_addr",  o_addr,       oa);
  endtask

  task automatic look(input string tag, input bit rev, input logic [4:0] cls,
                      input logic [31:0] a, input bit force_miss);
    logic eh, oh;
    logic [2:0] ew, ow;
    logic [31:0] ea, oa;
    model(1'b1, rev, cls, a, eh, ew, ea);
    model(1'b0, rev, cls, a, oh, ow, oa);
    if (force_miss) begin
      eh = 1'b0; ew = '0; ea = '0; oh = 1'b0; ow = '0; oa = '0;
    end
    req_valid = 1'b1; req_reverse = rev; req_class = cls; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0;
    check_rsp(tag, eh, ew, ea, oh, ow, oa);
  endtask

  task automatic shadow(input int w, input int sel, input logic [31:0] d);
    logic [31:0] m;
    m = (w % 4 == 0) ? 32'hFFFF_F000 : 32'hFFFF_0000;
    case (sel)
      0: s_ctrl[w]  = d;
      1: s_start[w] = d & m;
      2: s_bound[w] = d & m;
      3: s_offs[w]  = d & m;
      default: ;
    endcase
  endtask

  task automatic wr(input int w, input int sel, input logic [31:0] d);
    wr_en = 1'b1; wr_win = w[2:0]; wr_sel = sel[2:0]; wr_data = d;
    shadow(w, sel, d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic cfg(input int w, input logic [31:0] c, input logic [31:0] st,
                     input logic [31:0] bd, input logic [31:0] of);
    wr(w, 1, st);
    wr(w, 2, bd);
    wr(w, 3, of);
    wr(w, 0, c);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL R9 watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [4:0] c1;
    logic eh, oh;
    logic [2:0] ew, ow;
    logic [31:0] ea, oa;
    for (int w = 0; w < 8; w++) begin
      s_ctrl[w] = '0; s_start[w] = '0; s_bound[w] = '0; s_offs[w] = '0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    chk("R1", "valid_idle", 32'(n_valid), 32'd0);
    chk("R1", "old_valid_idle", 32'(o_valid), 32'd0);
    look("R1", 1'b1, 5'd0, 32'h0, 1'b1);
    look("R1", 1'b0, cls_of(2, 1, 1), 32'h8000_0000, 1'b1);

    // sweep: one distinct class per window, unaligned raw values
    for (int w = 0; w < 8; w++) begin
      logic [31:0] st;
      st = 32'(w) * 32'h1000_0000 + 32'h0123_4567;
      cfg(w, mk(1'b1, w % 3, w[0], w[1]), st, st + 32'h0050_0000,
          32'(w + 1) * 32'h0300_0000 + 32'h0000_0abc);
    end
    @(negedge clk);
    for (int w = 0; w < 8; w++) begin
      logic [4:0] cw;
      cw = cls_of(w % 3, w[0], w[1]);
      for (int k = 0; k < 5; k++) begin
        logic [31:0] a;
        case (k)
          0: a = s_start[w] - 32'd1;
          1: a = s_start[w];
          2: a = s_start[w] + 32'h1234;
          3: a = s_bound[w] - 32'd1;
          default: a = s_bound[w];
        endcase
        look("R6", 1'b1, cw, a, 1'b0);
        look("R7", 1'b0, cw, a + s_offs[w], 1'b0);
        look("R5", 1'b1, cw ^ 5'b00010, a, 1'b0);
        look("R5", 1'b0, cw ^ 5'b00001, a + s_offs[w], 1'b0);
      end
    end

    // R3: low bits cleared per window granularity
    look("R3", 1'b1, cls_of(1, 1, 0), 32'h1123_0000, 1'b0);
    look("R3", 1'b1, cls_of(1, 0, 0), 32'h4123_4000, 1'b0);
    look("R3", 1'b1, cls_of(1, 0, 0), 32'h4123_3fff, 1'b1);
    chk("R3", "start_mask_w0", s_start[0], 32'h0123_4000);

    // R6/R7 wraparound, window 6 also checks the absent upper half (R10)
    cfg(6, mk(1'b1, 0, 0, 1), 32'hFFF0_0000, 32'hFFFF_0000, 32'h0010_0000);
    @(negedge clk);
    look("R7", 1'b0, cls_of(0, 0, 1), 32'h0000_8000, 1'b0);
    look("R6", 1'b1, cls_of(0, 0, 1), 32'hFFF0_8000, 1'b0);
    look("R10", 1'b1, cls_of(0, 0, 1), 32'hFFF4_0000, 1'b0);

    // R5: invalid space code never hits
    cfg(3, mk(1'b1, 3, 0, 0), 32'h6000_0000, 32'h7000_0000, 32'h0);
    @(negedge clk);
    look("R5", 1'b1, cls_of(3, 0, 0), 32'h6800_0000, 1'b1);

    // R2: fields beyond offset change nothing and do not delay
    c1 = cls_of(1, 1, 0);
    wr(1, 4, 32'hFFFF_FFFF);
    look("R2", 1'b1, c1, s_start[1], 1'b0);
    wr(1, 7, 32'h0000_0000);
    look("R2", 1'b0, c1, s_start[1] + s_offs[1], 1'b0);

    // R11: settle hold after field write, disable at once, enable delay
    wr(1, 1, 32'h1123_0000);
    look("R11", 1'b1, c1, 32'h1123_0000, 1'b1);
    look("R11", 1'b1, c1, 32'h1123_0000, 1'b0);
    wr(1, 0, mk(1'b0, 1, 1, 0));
    look("R11", 1'b1, c1, 32'h1123_0000, 1'b0);
    wr(1, 0, mk(1'b1, 1, 1, 0));
    look("R11", 1'b1, c1, 32'h1123_0000, 1'b1);
    look("R11", 1'b1, c1, 32'h1123_0000, 1'b0);

    // R9: lookup concurrent with a disabling write sees the old state
    model(1'b1, 1'b1, c1, 32'h1123_0000, eh, ew, ea);
    model(1'b0, 1'b1, c1, 32'h1123_0000, oh, ow, oa);
    req_valid = 1'b1; req_reverse = 1'b1; req_class = c1; req_addr = 32'h1123_0000;
    wr_en = 1'b1; wr_win = 3'd1; wr_sel = 3'd0; wr_data = mk(1'b0, 1, 1, 0);
    shadow(1, 0, mk(1'b0, 1, 1, 0));
    @(negedge clk);
    req_valid = 1'b0; wr_en = 1'b0;
    check_rsp("R9", eh, ew, ea, oh, ow, oa);
    chk("R9", "hit_before_write", 32'(n_hit), 32'd1);
    @(negedge clk);
    chk("R9", "valid_drops", 32'(n_valid), 32'd0);
    chk("R9", "idle_addr", n_addr, 32'd0);

    // R8: all windows overlap with one class, remove winners one by one
    for (int w = 0; w < 8; w++)
      cfg(w, mk(1'b1, 2, 1, 1), 32'h8000_0000, 32'h9000_0000, 32'(w) * 32'h0001_0000);
    @(negedge clk);
    for (int d = 0; d < 8; d++) begin
      look("R8", 1'b1, cls_of(2, 1, 1), 32'h8800_0000, 1'b0);
      look("R8", 1'b0, cls_of(2, 1, 1), 32'h8800_0000 + 32'(d) * 32'h0001_0000, 1'b0);
      if (d == 4) look("R10", 1'b1, cls_of(2, 1, 1), 32'h8000_0000, 1'b0);
      wr(d, 0, mk(1'b0, 2, 1, 1));
      @(negedge clk);
    end
    // R4: every window now disabled
    look("R4", 1'b1, cls_of(2, 1, 1), 32'h8800_0000, 1'b1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule